// File: doc/BRIEF.md
# Coprocessor Bus Master Handshake Controller

This block shares a processor's multiplexed address/data bus between the CPU and an external agent such as a coprocessor, and it sequences the agent's strobes in both directions. When the agent asks for the bus, the controller requests the bus from the CPU. It grants the agent only once the CPU has released the bus, and it keeps that grant until the agent withdraws its request. While the agent holds the bus, the controller pulses an address latch enable to capture the address the agent drives, and it acknowledges that address one clock later. It then acknowledges a data beat once memory reports it is ready. For as long as it owns the bus, the controller also supplies the enables that hold the CPU's burst, read and write lines inactive.

In the other direction, the CPU reaches the agent as a slave. The controller asserts the agent chip select, and one clock later asserts the address and data strobes. It then waits for the agent's data acknowledge and completes the CPU access. The wait is bounded by a limit set at a port. If the acknowledge does not arrive within that many clocks, the access is aborted and an error is flagged for that access. Memory completion is modelled as a single ready input. All strobes are active low.

Top module: `cpbus_ctrl`

## Requirements
- R1: After reset, agt_gnt_n, cpu_busreq_n, agt_aack_n, agt_dtack_out_n, agt_cs_n, agt_as_out_n, agt_ds_out_n and cpu_ack_n are 1. ale, slv_err, burst_oe, rd_oe, wr_oe and ad_lo_addr are 0.
- R2: agt_req_n sampled low drives cpu_busreq_n low in the following cycle. agt_gnt_n goes low only in the cycle after an edge that samples cpu_busgnt_n low. If agt_req_n returns high before the grant, cpu_busreq_n returns high and no grant is given.
- R3: Once agt_gnt_n is low, it stays low while agt_req_n stays low, whatever cpu_busgnt_n does. In the cycle after agt_req_n is sampled high, agt_gnt_n and cpu_busreq_n are both 1.
- R4: While agt_gnt_n is low, burst_oe, rd_oe and ad_lo_addr are 1. ad_lo_addr = 1 means bits 3:2 of the address phase carry address bits, not byte enables. wr_oe is 1 unless agt_wr_n is 0, which marks an agent write. All four are 0 when the agent is not granted.
- R5: With the agent granted and no cycle open, agt_as_in_n sampled low makes ale 1 for exactly the next cycle. agt_aack_n is 0 for exactly the cycle after that.
- R6: After the address acknowledge, agt_dtack_out_n is 0 for one cycle, in the cycle after an edge that samples agt_ds_in_n low with mem_ready high. No further acknowledge is given until agt_as_in_n returns high.
- R7: cpu_acc sampled high while the agent is not granted drives agt_cs_n low in the next cycle. One cycle later, agt_as_out_n and agt_ds_out_n go low, and agt_cs_n stays low.
- R8: agt_dtack_in_n sampled low while the slave strobes are low ends the access. In the next cycle, all three slave strobes are 1, and cpu_ack_n is 0 for one cycle with slv_err 0.
- R9: Without an acknowledge, the slave strobes stay low for max(wait_limit,1) cycles. Then cpu_ack_n is 0 for one cycle with slv_err 1. An acknowledge sampled at the final edge wins, and slv_err stays 0.
- R10: cpu_acc is ignored while the agent is granted: agt_cs_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| agt_req_n | input | 1 | Agent bus request, active low |
| agt_gnt_n | output | 1 | Agent bus grant, active low |
| cpu_busreq_n | output | 1 | Bus request to the CPU, active low |
| cpu_busgnt_n | input | 1 | Bus grant from the CPU, active low |
| agt_wr_n | input | 1 | Agent master cycle is a write when low |
| agt_as_in_n | input | 1 | Agent address strobe in master mode |
| agt_ds_in_n | input | 1 | Agent data strobe in master mode |
| mem_ready | input | 1 | Memory has completed the data beat |
| ale | output | 1 | Address latch enable, active high |
| agt_aack_n | output | 1 | Address acknowledge to the agent |
| agt_dtack_out_n | output | 1 | Data acknowledge to the agent in master mode |
| burst_oe | output | 1 | Drive the CPU burst line inactive |
| rd_oe | output | 1 | Drive the CPU read line inactive |
| wr_oe | output | 1 | Drive the CPU write line inactive |
| ad_lo_addr | output | 1 | Address bits 3:2 carry address, not byte enables |
| cpu_acc | input | 1 | CPU access to the agent (slave mode) |
| wait_limit | input | 8 | Slave acknowledge timeout in clocks |
| agt_dtack_in_n | input | 1 | Agent data acknowledge in slave mode |
| agt_cs_n | output | 1 | Agent chip select |
| agt_as_out_n | output | 1 | Address strobe to the agent in slave mode |
| agt_ds_out_n | output | 1 | Data strobe to the agent in slave mode |
| cpu_ack_n | output | 1 | Slave access complete to the CPU |
| slv_err | output | 1 | Slave access aborted by timeout |

## Verification
Every registered result appears one clock after the edge that samples its cause. Bus request and grant appear one cycle after their inputs. The latch enable appears one cycle after the address strobe, and the address acknowledge one cycle after that. Chip select appears one cycle after the CPU access, and the slave strobes one cycle later. The completion appears one cycle after the acknowledge, or after exactly max(wait_limit,1) strobe cycles. Only the bus-drive enables follow agt_wr_n within the same cycle. The bench drives inputs on the falling edge and checks at the next falling edge, one rising edge later. It counts the strobe cycles one at a time and checks each one, so an early or late transition is seen in the cycle where it occurs.

// File: rtl/cpbus_pkg.sv
// Shared state encodings for the coprocessor bus handshake controller.
package cpbus_pkg;
    typedef enum logic [1:0] {ARB_IDLE, ARB_REQ, ARB_GNT} arb_st_t;
    typedef enum logic [2:0] {MC_IDLE, MC_ALE, MC_AACK, MC_DATA, MC_DTACK, MC_END} mcyc_st_t;
    typedef enum logic [1:0] {SL_IDLE, SL_CS, SL_STB, SL_END} slv_st_t;
endpackage

// File: rtl/cpbus_arb.sv
// Bus arbiter between CPU and agent.
// Requests the CPU bus on an agent request, grants the agent after the CPU
// grant, and holds that grant until the agent drops its request.
// Assumes all request/grant inputs are synchronous to clk.
module cpbus_arb
    import cpbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic agt_req_n,
    input  logic cpu_busgnt_n,
    output logic granted,
    output logic cpu_busreq_n,
    output logic agt_gnt_n
);
    arb_st_t st;

    // State register: request, wait for CPU grant, hold agent grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ARB_IDLE;
        end else begin
            case (st)
                ARB_IDLE: if (!agt_req_n) st <= ARB_REQ;
                ARB_REQ: begin
                    if (agt_req_n)          st <= ARB_IDLE;
                    else if (!cpu_busgnt_n) st <= ARB_GNT;
                end
                ARB_GNT:  if (agt_req_n) st <= ARB_IDLE;
                default:  st <= ARB_IDLE;
            endcase
        end
    end

    // Output decode from state only.
    always_comb begin
        granted      = (st == ARB_GNT);
        cpu_busreq_n = (st == ARB_IDLE);
        agt_gnt_n    = !granted;
    end
endmodule

// File: rtl/cpbus_mcyc.sv
// Master-mode cycle sequencer.
// While the agent owns the bus, it latches the agent address with a
// one-cycle ALE, acknowledges the address one clock later, then
// acknowledges one data beat once memory is ready.
// Assumes cyc_en drops the same cycle the agent releases its request.
module cpbus_mcyc
    import cpbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_en,
    input  logic agt_as_in_n,
    input  logic agt_ds_in_n,
    input  logic mem_ready,
    output logic ale,
    output logic agt_aack_n,
    output logic agt_dtack_out_n
);
    mcyc_st_t st;

    // State register: address latch, address ack, data wait, data ack, end.
    always_ff @(posedge clk) begin
        if (!rst_n || !cyc_en) begin
            st <= MC_IDLE;
        end else begin
            case (st)
                MC_IDLE:  if (!agt_as_in_n) st <= MC_ALE;
                MC_ALE:   st <= MC_AACK;
                MC_AACK:  st <= MC_DATA;
                MC_DATA:  if (!agt_ds_in_n && mem_ready) st <= MC_DTACK;
                MC_DTACK: st <= MC_END;
                MC_END:   if (agt_as_in_n) st <= MC_IDLE;
                default:  st <= MC_IDLE;
            endcase
        end
    end

    // Strobe decode from state only.
    always_comb begin
        ale             = (st == MC_ALE);
        agt_aack_n      = (st != MC_AACK);
        agt_dtack_out_n = (st != MC_DTACK);
    end
endmodule

// File: rtl/cpbus_slv.sv
// Slave-mode access sequencer with a bounded wait.
// A CPU access raises chip select, then address and data strobes one clock
// later, and waits for the agent acknowledge. If no acknowledge arrives
// within max(wait_limit,1) strobe cycles, the access completes with an error.
// Assumes cpu_acc is a request sampled only when idle.
module cpbus_slv
    import cpbus_pkg::*;
#(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              granted,
    input  logic              cpu_acc,
    input  logic [WAIT_W-1:0] wait_limit,
    input  logic              agt_dtack_in_n,
    output logic              agt_cs_n,
    output logic              agt_as_out_n,
    output logic              agt_ds_out_n,
    output logic              cpu_ack_n,
    output logic              slv_err
);
    localparam int CNT_W = WAIT_W + 1;

    slv_st_t          st;
    logic [CNT_W-1:0] wait_cnt;
    logic             err_q;
    logic             last_wait;

    // The wait expires once this strobe cycle reaches the limit.
    always_comb last_wait = (wait_cnt + 1'b1) >= {1'b0, wait_limit};

    // State, wait counter and error register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SL_IDLE;
            wait_cnt <= '0;
            err_q    <= 1'b0;
        end else begin
            case (st)
                SL_IDLE: if (cpu_acc && !granted) st <= SL_CS;
                SL_CS: begin
                    wait_cnt <= '0;
                    err_q    <= 1'b0;
                    st       <= SL_STB;
                end
                SL_STB: begin
                    if (!agt_dtack_in_n) begin
                        st <= SL_END;
                    end else if (last_wait) begin
                        err_q <= 1'b1;
                        st    <= SL_END;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                SL_END:  st <= SL_IDLE;
                default: st <= SL_IDLE;
            endcase
        end
    end

    // Strobe and completion decode from state.
    always_comb begin
        agt_cs_n     = !(st == SL_CS || st == SL_STB);
        agt_as_out_n = (st != SL_STB);
        agt_ds_out_n = (st != SL_STB);
        cpu_ack_n    = (st != SL_END);
        slv_err      = (st == SL_END) && err_q;
    end
endmodule

// File: rtl/cpbus_ctrl.sv
// Top level of the coprocessor bus handshake controller.
// Combines the arbiter, the master cycle sequencer and the slave sequencer,
// and produces the enables that hold the CPU control lines inactive while
// the agent owns the bus. wr_oe follows agt_wr_n within the same cycle.
module cpbus_ctrl #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              agt_req_n,
    output logic              agt_gnt_n,
    output logic              cpu_busreq_n,
    input  logic              cpu_busgnt_n,
    input  logic              agt_wr_n,
    input  logic              agt_as_in_n,
    input  logic              agt_ds_in_n,
    input  logic              mem_ready,
    output logic              ale,
    output logic              agt_aack_n,
    output logic              agt_dtack_out_n,
    output logic              burst_oe,
    output logic              rd_oe,
    output logic              wr_oe,
    output logic              ad_lo_addr,
    input  logic              cpu_acc,
    input  logic [WAIT_W-1:0] wait_limit,
    input  logic              agt_dtack_in_n,
    output logic              agt_cs_n,
    output logic              agt_as_out_n,
    output logic              agt_ds_out_n,
    output logic              cpu_ack_n,
    output logic              slv_err
);
    logic granted;
    logic cyc_en;

    cpbus_arb u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .agt_req_n    (agt_req_n),
        .cpu_busgnt_n (cpu_busgnt_n),
        .granted      (granted),
        .cpu_busreq_n (cpu_busreq_n),
        .agt_gnt_n    (agt_gnt_n)
    );

    // A master cycle may run only while the grant and the live request hold.
    always_comb cyc_en = granted && !agt_req_n;

    cpbus_mcyc u_mcyc (
        .clk             (clk),
        .rst_n           (rst_n),
        .cyc_en          (cyc_en),
        .agt_as_in_n     (agt_as_in_n),
        .agt_ds_in_n     (agt_ds_in_n),
        .mem_ready       (mem_ready),
        .ale             (ale),
        .agt_aack_n      (agt_aack_n),
        .agt_dtack_out_n (agt_dtack_out_n)
    );

    cpbus_slv #(.WAIT_W(WAIT_W)) u_slv (
        .clk            (clk),
        .rst_n          (rst_n),
        .granted        (granted),
        .cpu_acc        (cpu_acc),
        .wait_limit     (wait_limit),
        .agt_dtack_in_n (agt_dtack_in_n),
        .agt_cs_n       (agt_cs_n),
        .agt_as_out_n   (agt_as_out_n),
        .agt_ds_out_n   (agt_ds_out_n),
        .cpu_ack_n      (cpu_ack_n),
        .slv_err        (slv_err)
    );

    // CPU line hold-off enables while the agent owns the bus.
    always_comb begin
        burst_oe   = granted;
        rd_oe      = granted;
        wr_oe      = granted && agt_wr_n;
        ad_lo_addr = granted;
    end
endmodule

// File: rtl/cpbus_ctrl_chk.sv
// Protocol checker for cpbus_ctrl, bound to every instance.
// Watches only the ports of the top module.
module cpbus_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic agt_req_n,
    input logic agt_gnt_n,
    input logic cpu_busreq_n,
    input logic cpu_busgnt_n,
    input logic ale,
    input logic agt_aack_n,
    input logic burst_oe,
    input logic rd_oe,
    input logic agt_cs_n,
    input logic agt_as_out_n,
    input logic cpu_ack_n,
    input logic slv_err
);
    assert_gnt_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !agt_gnt_n |-> !cpu_busreq_n);
    assert_gnt_after_cpu_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(agt_gnt_n) |-> $past(!cpu_busgnt_n));
    assert_gnt_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!agt_gnt_n && !agt_req_n) |=> !agt_gnt_n);
    assert_oe_while_gnt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !agt_gnt_n |-> (burst_oe && rd_oe));
    assert_ale_then_aack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!agt_aack_n && !ale));
    assert_aack_after_ale_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !agt_aack_n |-> $past(ale));
    assert_cs_leads_as_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(agt_as_out_n) |-> $past(!agt_cs_n));
    assert_as_within_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !agt_as_out_n |-> !agt_cs_n);
    assert_err_with_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slv_err |-> (!cpu_ack_n && agt_as_out_n));
endmodule

bind cpbus_ctrl cpbus_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .agt_req_n    (agt_req_n),
    .agt_gnt_n    (agt_gnt_n),
    .cpu_busreq_n (cpu_busreq_n),
    .cpu_busgnt_n (cpu_busgnt_n),
    .ale          (ale),
    .agt_aack_n   (agt_aack_n),
    .burst_oe     (burst_oe),
    .rd_oe        (rd_oe),
    .agt_cs_n     (agt_cs_n),
    .agt_as_out_n (agt_as_out_n),
    .cpu_ack_n    (cpu_ack_n),
    .slv_err      (slv_err)
);

// File: tb/sim_cpbus_ctrl.sv
`timescale 1ns/1ps
// Directed bench for cpbus_ctrl: one task per scenario.
module sim_cpbus_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       agt_req_n, cpu_busgnt_n, agt_wr_n, agt_as_in_n, agt_ds_in_n, mem_ready;
    logic       cpu_acc, agt_dtack_in_n;
    logic [7:0] wait_limit;
    logic       agt_gnt_n, cpu_busreq_n, ale, agt_aack_n, agt_dtack_out_n;
    logic       burst_oe, rd_oe, wr_oe, ad_lo_addr;
    logic       agt_cs_n, agt_as_out_n, agt_ds_out_n, cpu_ack_n, slv_err;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    cpbus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .agt_req_n(agt_req_n), .agt_gnt_n(agt_gnt_n),
        .cpu_busreq_n(cpu_busreq_n), .cpu_busgnt_n(cpu_busgnt_n), .agt_wr_n(agt_wr_n),
        .agt_as_in_n(agt_as_in_n), .agt_ds_in_n(agt_ds_in_n), .mem_ready(mem_ready),
        .ale(ale), .agt_aack_n(agt_aack_n), .agt_dtack_out_n(agt_dtack_out_n),
        .burst_oe(burst_oe), .rd_oe(rd_oe), .wr_oe(wr_oe), .ad_lo_addr(ad_lo_addr),
        .cpu_acc(cpu_acc), .wait_limit(wait_limit), .agt_dtack_in_n(agt_dtack_in_n),
        .agt_cs_n(agt_cs_n), .agt_as_out_n(agt_as_out_n), .agt_ds_out_n(agt_ds_out_n),
        .cpu_ack_n(cpu_ack_n), .slv_err(slv_err)
    );

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // One rising edge; inputs change and outputs are read on falling edges.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; agt_req_n = 1'b1; cpu_busgnt_n = 1'b1; agt_wr_n = 1'b1;
        agt_as_in_n = 1'b1; agt_ds_in_n = 1'b1; mem_ready = 1'b0;
        cpu_acc = 1'b0; agt_dtack_in_n = 1'b1; wait_limit = 8'd4;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 master idle {gnt,breq,aack,dtack,ale}",
            {11'd0, agt_gnt_n, cpu_busreq_n, agt_aack_n, agt_dtack_out_n, ale}, 16'h001e);
        chk("R1 slave idle {cs,as,ds,ack,err}",
            {11'd0, agt_cs_n, agt_as_out_n, agt_ds_out_n, cpu_ack_n, slv_err}, 16'h001e);
        chk("R1 oe {burst,rd,wr,lo}", {12'd0, burst_oe, rd_oe, wr_oe, ad_lo_addr}, 16'h0);
    endtask

    // Bring the agent to the granted state.
    task automatic get_grant();
        agt_req_n = 1'b0;
        step();
        chk("R2 busreq after request", {15'd0, cpu_busreq_n}, 16'h0);
        chk("R2 no grant before cpu grant", {15'd0, agt_gnt_n}, 16'h1);
        step();
        chk("R2 still no grant", {15'd0, agt_gnt_n}, 16'h1);
        cpu_busgnt_n = 1'b0;
        step();
        chk("R2 grant after cpu grant", {15'd0, agt_gnt_n}, 16'h0);
    endtask

    task automatic drop_grant();
        agt_req_n = 1'b1;
        step();
        chk("R3 release {gnt,breq}", {14'd0, agt_gnt_n, cpu_busreq_n}, 16'h3);
        chk("R4 oe off after release", {12'd0, burst_oe, rd_oe, wr_oe, ad_lo_addr}, 16'h0);
        cpu_busgnt_n = 1'b1;
        step();
    endtask

    task automatic t_withdraw();
        agt_req_n = 1'b0;
        step();
        chk("R2 busreq raised", {15'd0, cpu_busreq_n}, 16'h0);
        agt_req_n = 1'b1;
        step();
        chk("R2 withdrawn busreq", {15'd0, cpu_busreq_n}, 16'h1);
        cpu_busgnt_n = 1'b0;
        step();
        chk("R2 withdrawn no grant", {15'd0, agt_gnt_n}, 16'h1);
        cpu_busgnt_n = 1'b1;
        step();
    endtask

    task automatic t_master_read();
        get_grant();
        chk("R4 oe read {burst,rd,wr,lo}", {12'd0, burst_oe, rd_oe, wr_oe, ad_lo_addr}, 16'hf);
        cpu_busgnt_n = 1'b1;
        step();
        chk("R3 grant held after cpu release", {15'd0, agt_gnt_n}, 16'h0);
        agt_as_in_n = 1'b0;
        step();
        chk("R5 ale cycle {ale,aack}", {14'd0, ale, agt_aack_n}, 16'h3);
        step();
        chk("R5 aack cycle {ale,aack}", {14'd0, ale, agt_aack_n}, 16'h0);
        agt_ds_in_n = 1'b0;
        step();
        chk("R5 aack one cycle", {15'd0, agt_aack_n}, 16'h1);
        chk("R6 no dtack without ready", {15'd0, agt_dtack_out_n}, 16'h1);
        mem_ready = 1'b1;
        step();
        chk("R6 dtack", {15'd0, agt_dtack_out_n}, 16'h0);
        step();
        chk("R6 dtack one cycle", {15'd0, agt_dtack_out_n}, 16'h1);
        step();
        chk("R6 no repeat while as held", {14'd0, agt_dtack_out_n, ale}, 16'h2);
        agt_as_in_n = 1'b1; agt_ds_in_n = 1'b1; mem_ready = 1'b0;
        step();
        step();
        chk("R5 no ale after release", {15'd0, ale}, 16'h0);
        drop_grant();
    endtask

    task automatic t_master_write();
        get_grant();
        agt_wr_n = 1'b0;
        #0.5;
        chk("R4 wr_oe off on agent write", {13'd0, burst_oe, rd_oe, wr_oe}, 16'h6);
        agt_wr_n = 1'b1;
        #0.5;
        chk("R4 wr_oe back on", {15'd0, wr_oe}, 16'h1);
        cpu_busgnt_n = 1'b1;
        drop_grant();
    endtask

    task automatic t_slave_ok();
        wait_limit = 8'd4;
        cpu_acc = 1'b1;
        step();
        cpu_acc = 1'b0;
        chk("R7 cs first {cs,as,ds}", {13'd0, agt_cs_n, agt_as_out_n, agt_ds_out_n}, 16'h3);
        step();
        chk("R7 strobes {cs,as,ds}", {13'd0, agt_cs_n, agt_as_out_n, agt_ds_out_n}, 16'h0);
        step();
        chk("R8 waiting no ack", {15'd0, cpu_ack_n}, 16'h1);
        agt_dtack_in_n = 1'b0;
        step();
        agt_dtack_in_n = 1'b1;
        chk("R8 end {cs,as,ds,ack,err}",
            {11'd0, agt_cs_n, agt_as_out_n, agt_ds_out_n, cpu_ack_n, slv_err}, 16'h1c);
        step();
        chk("R8 ack one cycle", {15'd0, cpu_ack_n}, 16'h1);
    endtask

    task automatic t_slave_timeout(input logic [7:0] lim);
        int cycles;
        wait_limit = lim;
        cycles = (lim == 8'd0) ? 1 : int'(lim);
        cpu_acc = 1'b1;
        step();
        cpu_acc = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            step();
            chk($sformatf("R9 lim %0d strobe cycle %0d {as,ack}", lim, i),
                {14'd0, agt_as_out_n, cpu_ack_n}, 16'h1);
        end
        step();
        chk($sformatf("R9 lim %0d abort {as,ack,err}", lim),
            {13'd0, agt_as_out_n, cpu_ack_n, slv_err}, 16'h5);
        step();
        chk("R9 err one cycle", {14'd0, cpu_ack_n, slv_err}, 16'h2);
    endtask

    task automatic t_slave_race();
        wait_limit = 8'd1;
        cpu_acc = 1'b1;
        step();
        cpu_acc = 1'b0;
        step();
        agt_dtack_in_n = 1'b0;
        step();
        agt_dtack_in_n = 1'b1;
        chk("R9 ack beats timeout {ack,err}", {14'd0, cpu_ack_n, slv_err}, 16'h0);
        step();
    endtask

    task automatic t_slave_ignored();
        get_grant();
        cpu_acc = 1'b1;
        step();
        chk("R10 no cs while granted", {15'd0, agt_cs_n}, 16'h1);
        step();
        chk("R10 no strobes while granted", {14'd0, agt_cs_n, agt_as_out_n}, 16'h3);
        cpu_acc = 1'b0;
        drop_grant();
        chk("R10 still idle after release", {14'd0, agt_cs_n, cpu_ack_n}, 16'h3);
    endtask

    initial begin
        t_reset();
        t_withdraw();
        t_master_read();
        t_master_write();
        t_slave_ok();
        t_slave_timeout(8'd3);
        t_slave_timeout(8'd0);
        t_slave_race();
        t_slave_ignored();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule